// File: doc/BRIEF.md
# Q-Subcode Block Capture Buffer

This block assembles an 80-bit Q-channel subcode block from a serial stream that delivers one bit per received audio frame. A marker that accompanies a bit flags it as the first bit of a block. The incoming bits collect in a private shadow register. Once the eightieth bit arrives, the whole block moves in one step into a readable bank of ten bytes, and a one-cycle ready pulse is raised.

Software picks a byte with a 4-bit index and reads it through a combinational data port. A frame-based read window tells software how long the captured block is guaranteed to stay in place. A sticky overrun flag reports that a newer block replaced one that software had not yet acknowledged.

Top module: `qsub_capture`

## Requirements
- R1: A bit is taken only in a cycle with `bit_valid` high. A bit with `blk_start` high becomes Q[0] and starts a block. Bits that arrive while no block is open are ignored: this covers bits before the first marker and bits after the 80th bit until the next marker.
- R2: Byte k of the readable bank holds Q[8k+j] in bit position 7-j. Q[0] is therefore bit 7 of byte 0, Q[7] is bit 0 of byte 0, and Q[79] is bit 0 of byte 9.
- R3: `rd_data` follows `rd_idx` combinationally. Index values 10 to 15 read as 0x00.
- R4: `blk_ready` is high for exactly one clock cycle. It is sampled high at the second rising edge after the edge that took Q[79]. In that same cycle the new block is already readable.
- R5: The readable bytes change only in the cycle in which `blk_ready` is high. A block that is still being captured is never visible on `rd_data`.
- R6: A marker that arrives before 80 bits have been collected discards the partial block and restarts capture at Q[0]. No ready pulse is raised for the discarded part.
- R7: `window_open` rises together with `blk_ready`. It stays high for exactly READ_WINDOW frames (cycles with `bit_valid` high) after that. The default for READ_WINDOW is 588.
- R8: A block that completes while the previous block is still unacknowledged sets `overrun`, and the flag stays set. A one-cycle `ack` clears both the overrun flag and the pending state.
- R9: After reset all ten bytes read 0x00, and `blk_ready`, `window_open` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | One subcode bit is offered this cycle (one per frame) |
| bit_in | input | 1 | Subcode bit value |
| blk_start | input | 1 | Marks the offered bit as Q[0] |
| ack | input | 1 | Software acknowledges the current block |
| rd_idx | input | 4 | Byte index for reading |
| rd_data | output | 8 | Selected byte of the readable bank |
| blk_ready | output | 1 | One-cycle pulse: a new block is readable |
| window_open | output | 1 | The guaranteed read window of the current block is still running |
| overrun | output | 1 | A block was replaced before it was acknowledged |

## Verification
The bound checker watches four things on every cycle:
- the ready pulse stays one cycle wide and comes two edges after a taken bit;
- the readable byte only moves together with the ready pulse;
- out-of-range indices read as zero;
- an acknowledge clears the overrun flag, and the window is open whenever a block lands.

Some behaviour only the bench scenarios can show. These are the exact bit-to-byte placement and the discarding of a partial block on an early marker. They also include ignoring bits with no open block, the exact 588-frame length of the window, and an overrun being raised by a second unacknowledged block. Each of these depends on a chosen stimulus history that the scoreboard compares against its own model.

// File: rtl/qsub_pkg.sv
// Package: shared constants and types for the Q-subcode capture buffer.
// Assumes byte-wide readout and a block length that is a multiple of the byte width.
package qsub_pkg;
    parameter int unsigned QSUB_BITS   = 80;
    parameter int unsigned QSUB_BYTE_W = 8;
    parameter int unsigned QSUB_WINDOW = 588;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/qsub_shift.sv
// Module: serial collector for one subcode block.
// Writes each accepted bit to its position in a shadow register and pulses
// commit_o once the last bit of a block is stored. Assumes at most one bit per cycle.
module qsub_shift
    import qsub_pkg::*;
#(
    parameter int unsigned Q_BITS = QSUB_BITS,
    localparam int unsigned CNT_W = $clog2(Q_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              blk_start,
    output logic [Q_BITS-1:0] shadow_o,
    output logic              commit_o
);
    cap_state_e       state_q;
    logic [CNT_W-1:0] pos_q;

    // Collect bits into the shadow and track the position within the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CAP_IDLE;
            pos_q    <= '0;
            shadow_o <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (bit_valid) begin
                if (blk_start) begin
                    shadow_o[0] <= bit_in;
                    pos_q       <= CNT_W'(1);
                    state_q     <= CAP_RUN;
                end else if (state_q == CAP_RUN) begin
                    shadow_o[pos_q] <= bit_in;
                    if (pos_q == CNT_W'(Q_BITS - 1)) begin
                        commit_o <= 1'b1;
                        state_q  <= CAP_IDLE;
                        pos_q    <= '0;
                    end else begin
                        pos_q <= pos_q + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qsub_bank.sv
// Module: readable bank of the captured block.
// Copies the whole shadow in one cycle on load_i and serves bytes by index,
// placing the earliest bit of each byte in its most significant position.
// Indices beyond the last byte read as zero.
module qsub_bank
    import qsub_pkg::*;
#(
    parameter int unsigned Q_BITS  = QSUB_BITS,
    parameter int unsigned BYTE_W  = QSUB_BYTE_W,
    localparam int unsigned N_BYTES = Q_BITS / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(N_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [Q_BITS-1:0] shadow_i,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    logic [Q_BITS-1:0] bank_q;
    logic [BYTE_W-1:0] byte_view [N_BYTES];

    // Take a complete block from the shadow in a single step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_i) begin
            bank_q <= shadow_i;
        end
    end

    // Reverse the bit order inside each byte so that arrival order runs MSB-first.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
            assign byte_view[k][BYTE_W-1-j] = bank_q[k*BYTE_W + j];
        end
    end

    // Select the addressed byte; unused indices return zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = byte_view[k];
            end
        end
    end
endmodule

// File: rtl/qsub_event.sv
// Module: block event logic.
// Raises the ready pulse one cycle after commit, times the read window in
// frames, and keeps the pending/overrun state. Assumes ack is a short pulse.
module qsub_event
    import qsub_pkg::*;
#(
    parameter int unsigned READ_WINDOW = QSUB_WINDOW,
    localparam int unsigned WIN_W = $clog2(READ_WINDOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    input  logic bit_valid,
    input  logic ack,
    output logic blk_ready,
    output logic window_open,
    output logic overrun
);
    logic             pending_q;
    logic [WIN_W-1:0] win_cnt_q;

    // Ready pulse lines up with the bank load.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_ready <= 1'b0;
        else        blk_ready <= commit_i;
    end

    // Pending and overrun bookkeeping for the software handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            overrun   <= 1'b0;
        end else if (commit_i) begin
            pending_q <= 1'b1;
            overrun   <= pending_q & ~ack;
        end else if (ack) begin
            pending_q <= 1'b0;
            overrun   <= 1'b0;
        end
    end

    // Frame counter that bounds the guaranteed read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_open <= 1'b0;
            win_cnt_q   <= '0;
        end else if (commit_i) begin
            window_open <= 1'b1;
            win_cnt_q   <= '0;
        end else if (window_open && bit_valid) begin
            if (win_cnt_q == WIN_W'(READ_WINDOW - 1)) begin
                window_open <= 1'b0;
            end else begin
                win_cnt_q <= win_cnt_q + WIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/qsub_capture.sv
// Module: top of the Q-subcode capture buffer.
// Connects the serial collector, the double-buffered readable bank and the
// event logic. Assumes inputs are synchronous to clk.
module qsub_capture
    import qsub_pkg::*;
#(
    parameter int unsigned Q_BITS      = QSUB_BITS,
    parameter int unsigned BYTE_W      = QSUB_BYTE_W,
    parameter int unsigned READ_WINDOW = QSUB_WINDOW,
    localparam int unsigned N_BYTES = Q_BITS / BYTE_W,
    localparam int unsigned IDX_W   = $clog2(N_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              blk_start,
    input  logic              ack,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              blk_ready,
    output logic              window_open,
    output logic              overrun
);
    logic [Q_BITS-1:0] shadow;
    logic              commit;

    qsub_shift #(.Q_BITS(Q_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .blk_start(blk_start),
        .shadow_o (shadow),
        .commit_o (commit)
    );

    qsub_bank #(.Q_BITS(Q_BITS), .BYTE_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (commit),
        .shadow_i(shadow),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    qsub_event #(.READ_WINDOW(READ_WINDOW)) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .bit_valid  (bit_valid),
        .ack        (ack),
        .blk_ready  (blk_ready),
        .window_open(window_open),
        .overrun    (overrun)
    );
endmodule

// File: rtl/qsub_capture_chk.sv
// Module: property checker for qsub_capture, attached through bind.
// Assumes the default geometry of ten bytes behind a 4-bit index.
module qsub_capture_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       ack,
    input logic [3:0] rd_idx,
    input logic [7:0] rd_data,
    input logic       blk_ready,
    input logic       window_open,
    input logic       overrun
);
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |=> !blk_ready); // R4
    AST_READY_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> $past(bit_valid, 2)); // R4
    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx) && !blk_ready) |-> $stable(rd_data)); // R5
    AST_HIGH_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= 4'd10) |-> (rd_data == 8'h00)); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !blk_ready && !$past(blk_ready)) |=> !overrun); // R8
    AST_WINDOW_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> window_open); // R7
endmodule

bind qsub_capture qsub_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .ack        (ack),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .blk_ready  (blk_ready),
    .window_open(window_open),
    .overrun    (overrun)
);

// File: tb/qsub_capture_tb.sv
`timescale 1ns/100ps
module qsub_capture_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       blk_start = 1'b0;
    logic       ack = 1'b0;
    logic [3:0] rd_idx = 4'd0;
    logic [7:0] rd_data;
    logic       blk_ready, window_open, overrun;

    int n_checks = 0;
    int n_fail   = 0;
    int n_ready  = 0;
    int n_pushed = 0;
    logic [79:0] exp_q [$];

    always #2 clk = ~clk;

    qsub_capture u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .blk_start(blk_start), .ack(ack), .rd_idx(rd_idx), .rd_data(rd_data),
        .blk_ready(blk_ready), .window_open(window_open), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Model of the byte layout: first-arriving bit of a byte in bit 7.
    function automatic logic [7:0] exp_byte(logic [79:0] q, int k);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7-j] = q[8*k + j];
        return b;
    endfunction

    // Driver: offer bits [from, to) of q, one frame every two cycles.
    task automatic send_bits(input logic [79:0] q, input int from, input int to, input bit mark);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in    = q[i];
            blk_start = mark && (i == from);
            @(negedge clk);
            bit_valid = 1'b0;
            blk_start = 1'b0;
        end
    endtask

    task automatic send_block(input logic [79:0] q);
        exp_q.push_back(q);
        n_pushed++;
        send_bits(q, 0, 80, 1'b1);
    endtask

    // After the last bit: no ready yet, then ready on the following cycle.
    task automatic expect_ready();
        chk(blk_ready == 1'b0, "R4 ready too early", blk_ready, 0);
        @(negedge clk);
        chk(blk_ready == 1'b1, "R4 ready latency", blk_ready, 1);
        chk(window_open == 1'b1, "R7 window opens with ready", window_open, 1);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in    = 1'b1;
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Monitor: pop the expected block on each ready pulse and compare all bytes.
    always @(negedge clk) begin
        if (rst_n && blk_ready) begin
            logic [79:0] e;
            n_ready++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected ready", 1, 0);
            end else begin
                e = exp_q.pop_front();
                for (int k = 0; k < 10; k++) begin
                    rd_idx = 4'(k);
                    #0.1;
                    chk(rd_data == exp_byte(e, k), "R2 byte content", rd_data, exp_byte(e, k));
                end
                rd_idx = 4'd0;
            end
            @(negedge clk);
            chk(blk_ready == 1'b0, "R4 single-cycle pulse", blk_ready, 0);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [79:0] blk_a, blk_b, blk_c, blk_m, junk;
        blk_a = 80'hA5C3_0F1E_7788_9BCD_E124;
        blk_b = 80'h1234_5678_9ABC_DEF0_1357;
        blk_c = 80'hFFFF_0000_5A5A_C33C_8001;
        blk_m = '0;
        blk_m[0]  = 1'b1;
        blk_m[79] = 1'b1;
        junk = '1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        for (int k = 0; k < 10; k++) begin
            rd_idx = 4'(k);
            #0.1;
            chk(rd_data == 8'h00, "R9 reset byte", rd_data, 0);
        end
        rd_idx = 4'd0;
        chk(!blk_ready && !window_open && !overrun, "R9 reset flags",
            {blk_ready, window_open, overrun}, 0);

        // R1: bits with no marker are ignored
        send_bits(junk, 0, 90, 1'b0);
        repeat (3) @(negedge clk);
        chk(n_ready == 0, "R1 no block without marker", n_ready, 0);

        // R2: corner bits Q[0] and Q[79]
        send_block(blk_m);
        expect_ready();
        repeat (2) @(negedge clk);
        rd_idx = 4'd0; #0.1;
        chk(rd_data == 8'h80, "R2 Q0 in bit 7 of byte 0", rd_data, 8'h80);
        rd_idx = 4'd9; #0.1;
        chk(rd_data == 8'h01, "R2 Q79 in bit 0 of byte 9", rd_data, 8'h01);
        pulse_ack();

        // R3: indices past the last byte read zero
        for (int k = 10; k < 16; k++) begin
            rd_idx = 4'(k);
            #0.1;
            chk(rd_data == 8'h00, "R3 high index", rd_data, 0);
        end
        rd_idx = 4'd0;

        // R5: capture in progress is not visible
        exp_q.push_back(blk_a);
        n_pushed++;
        send_bits(blk_a, 0, 40, 1'b1);
        rd_idx = 4'd0; #0.1;
        chk(rd_data == 8'h80, "R5 old byte 0 kept mid-capture", rd_data, 8'h80);
        send_bits(blk_a, 40, 80, 1'b0);
        expect_ready();
        repeat (2) @(negedge clk);
        chk(overrun == 1'b0, "R8 no overrun after ack", overrun, 0);

        // R6: early marker discards a partial block
        pulse_ack();
        send_bits(junk, 0, 30, 1'b1);
        send_block(blk_b);
        expect_ready();
        repeat (2) @(negedge clk);
        chk(n_ready == 3, "R6 one ready for restarted block", n_ready, 3);

        // R7: window length in frames, and R1: bits after a block are ignored
        pulse_ack();
        send_block(blk_c);
        expect_ready();
        frames(587);
        chk(window_open == 1'b1, "R7 window open after 587 frames", window_open, 1);
        frames(1);
        chk(window_open == 1'b0, "R7 window closed after 588 frames", window_open, 0);
        chk(n_ready == 4, "R1 no block from unmarked bits", n_ready, 4);

        // R8: second unacknowledged block raises overrun, ack clears it
        send_block(blk_a);
        expect_ready();
        @(negedge clk);
        chk(overrun == 1'b1, "R8 overrun on unacknowledged block", overrun, 1);
        pulse_ack();
        chk(overrun == 1'b0, "R8 ack clears overrun", overrun, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all blocks reported", exp_q.size(), 0);
        chk(n_ready == n_pushed, "R4 ready count", n_ready, n_pushed);
        finish_run();
    end
endmodule